// File: doc/BRIEF.md
# Two-Lane Variable Node Update Unit

This block performs the variable-node step of an iterative min-sum style LDPC decoder for one code column at a time. A node begins with a start pulse, which carries the channel log-likelihood ratio and the column weight of that node. The check-to-variable messages for the node then arrive two per clock. The unit adds the channel value and every incoming message into one wide total. It keeps each accepted pair so that it can play the pairs back afterwards.

Once the last pair has been taken, the unit emits the outgoing variable-to-check messages two per clock, in the order the pairs arrived. Each outgoing message is the shared total minus the message that came in on that same edge, clipped to the signed message range. Alongside each output pair it shows the hard decision, which is the sign of the total. After the final iteration the surrounding decoder takes this decision as the decoded bit. A node of weight b takes about b/2 clocks to gather and b/2 clocks to emit.

Messages and the channel value are `MSG_W`-bit two's complement numbers (6 bits by default). `MAX_WT` (8 by default) bounds the column weight.

Top module: `vnu_pair_update`

## Requirements
- R1: Reset drives ext_valid, ext_b_valid, hard_bit, ext_a and ext_b to 0. Whenever ext_valid is low, ext_a and ext_b read 0.
- R2: A node_start seen while the unit is idle captures chan_llr and col_wt. col_wt must lie in 1..MAX_WT. A node_start seen while a node is being gathered or emitted is ignored and changes no result.
- R3: A message pair counts only when msg_valid is high during gathering, and exactly ceil(col_wt/2) pairs are taken. msg_valid while idle or emitting is ignored. msg_a carries the lower-numbered edge of each pair.
- R4: The total is chan_llr plus every accepted message, with no internal overflow. For an odd column weight, msg_b of the final pair is excluded from the total.
- R5: Suppose the final pair is sampled at rising edge k. Then ext_valid is high after edges k+1 through k+ceil(col_wt/2), and low at every other time.
- R6: The j-th output pair belongs to the j-th accepted pair. ext_a equals the total minus that pair's msg_a, and ext_b equals the total minus that pair's msg_b.
- R7: Outgoing messages are clipped to the range ±(2^(MSG_W-1)-1), which is ±31 by default. The most negative code never appears on ext_a or ext_b.
- R8: ext_b_valid equals ext_valid on every output pair except the final pair of an odd-weight node. On that pair ext_b_valid is low and ext_b is 0.
- R9: hard_bit is 1 when the total is negative and 0 when the total is zero or positive. It updates together with the first output pair of a node, stays constant through that node's outputs, and holds until the next node's first output.
- R10: Cycles with msg_valid low during gathering only stall the unit. The result is the same as for back-to-back pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_start | input | 1 | Begins a node; taken only when idle |
| chan_llr | input | MSG_W | Channel LLR of the node, signed |
| col_wt | input | $clog2(MAX_WT+1) | Column weight of the node, 1..MAX_WT |
| msg_valid | input | 1 | A check-to-variable message pair is present |
| msg_a | input | MSG_W | First incoming message of the pair, signed |
| msg_b | input | MSG_W | Second incoming message of the pair, signed |
| ext_valid | output | 1 | An outgoing message pair is present |
| ext_a | output | MSG_W | Extrinsic message for the first edge of the pair |
| ext_b | output | MSG_W | Extrinsic message for the second edge of the pair |
| ext_b_valid | output | 1 | ext_b belongs to a real edge |
| hard_bit | output | 1 | Sign of the node total (1 = negative) |

## Verification
Every output pair of a node is derived from one total, so an accumulator error shows up on every pair at once, and a pair-buffer or ordering error shows up only on the pair it hits. A wrong pair counter is visible at the ports within a few clocks: ext_valid rises a cycle early or late, the burst has the wrong length, or lane b is not masked on an odd weight. A start or message pulse that leaks into the datapath while the unit is busy or idle corrupts the next node's total. The bench therefore compares every output on every clock against a behavioural model that counts edges, and it follows each such disturbance with a node whose result is known.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

    localparam int MSG_W   = 6;
    localparam int MSG_MAX = (1 << (MSG_W - 1)) - 1;

    typedef logic signed [MSG_W-1:0] msg_t;

    // One stored edge pair; b_live marks a real second edge
    typedef struct packed {
        msg_t lane_a;
        msg_t lane_b;
        logic b_live;
    } edge_pair_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GATHER = 2'd1,
        PH_EMIT   = 2'd2
    } phase_e;

    // Symmetric clip of a wide difference into the message range
    function automatic msg_t clip_msg(input int v);
        if (v > MSG_MAX) begin
            return msg_t'(MSG_MAX);
        end else if (v < -MSG_MAX) begin
            return msg_t'(-MSG_MAX);
        end else begin
            return msg_t'(v);
        end
    endfunction

endpackage

// File: rtl/vnu_seq.sv
module vnu_seq
    import vnu_pkg::*;
#(
    parameter int MAX_WT = 8,
    localparam int WT_W      = $clog2(MAX_WT + 1),
    localparam int MAX_PAIRS = (MAX_WT + 1) / 2,
    localparam int IDX_W     = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             node_start,
    input  logic [WT_W-1:0]  col_wt,
    input  logic             msg_valid,
    output logic             load_en,
    output logic             take,
    output logic             emit,
    output logic             b_live,
    output logic [IDX_W-1:0] pair_idx
);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] last_c;
    logic [WT_W:0]    npairs_c;
    logic             odd_q;
    logic             at_last;

    always_comb begin
        npairs_c = ({1'b0, col_wt} + 1'b1) >> 1;
        last_c   = IDX_W'(npairs_c - 1'b1);
    end

    assign at_last  = (idx_q == last_q);
    assign load_en  = node_start && (phase_q == PH_IDLE);
    assign take     = msg_valid && (phase_q == PH_GATHER);
    assign emit     = (phase_q == PH_EMIT);
    assign b_live   = !(at_last && odd_q);
    assign pair_idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            odd_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (node_start) begin
                        phase_q <= PH_GATHER;
                        idx_q   <= '0;
                        last_q  <= last_c;
                        odd_q   <= col_wt[0];
                    end
                end
                PH_GATHER: begin
                    if (msg_valid) begin
                        if (at_last) begin
                            phase_q <= PH_EMIT;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_EMIT: begin
                    if (at_last) begin
                        phase_q <= PH_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vnu_pair_store.sv
module vnu_pair_store
    import vnu_pkg::*;
#(
    parameter int MAX_WT = 8,
    localparam int MAX_PAIRS = (MAX_WT + 1) / 2,
    localparam int IDX_W     = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1
)(
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  edge_pair_t       wr_pair,
    output edge_pair_t       rd_pair
);

    edge_pair_t slot_q [MAX_PAIRS];

    // Every slot read during playback was written in the same node
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[idx] <= wr_pair;
        end
    end

    assign rd_pair = slot_q[idx];

endmodule

// File: rtl/vnu_sum_acc.sv
module vnu_sum_acc
    import vnu_pkg::*;
#(
    parameter int MAX_WT = 8,
    localparam int SUM_W = MSG_W + $clog2(MAX_WT + 1)
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic                    add_en,
    input  msg_t                    llr,
    input  edge_pair_t              pair,
    output logic signed [SUM_W-1:0] total
);

    logic signed [SUM_W-1:0] acc_q;

    function automatic logic signed [SUM_W-1:0] widen(input msg_t v);
        return {{(SUM_W - MSG_W){v[MSG_W-1]}}, v};
    endfunction

    // lane_b arrives already zeroed when it is not a real edge
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (load_en) begin
            acc_q <= widen(llr);
        end else if (add_en) begin
            acc_q <= acc_q + widen(pair.lane_a) + widen(pair.lane_b);
        end
    end

    assign total = acc_q;

endmodule

// File: rtl/vnu_extrinsic.sv
module vnu_extrinsic
    import vnu_pkg::*;
#(
    parameter int SUM_W = 10
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    emit,
    input  logic signed [SUM_W-1:0] total,
    input  edge_pair_t              rd_pair,
    output msg_t                    lane_o [2],
    output logic                    valid_o,
    output logic                    b_valid_o,
    output logic                    hard_o
);

    for (genvar L = 0; L < 2; L++) begin : g_lane
        msg_t src;
        logic live;
        msg_t q;

        assign src  = (L == 0) ? rd_pair.lane_a : rd_pair.lane_b;
        assign live = (L == 0) ? 1'b1 : rd_pair.b_live;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (emit && live) begin
                q <= clip_msg(int'(total) - int'(src));
            end else begin
                q <= '0;
            end
        end

        assign lane_o[L] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            b_valid_o <= 1'b0;
            hard_o    <= 1'b0;
        end else begin
            valid_o   <= emit;
            b_valid_o <= emit && rd_pair.b_live;
            if (emit) begin
                hard_o <= total[SUM_W-1];
            end
        end
    end

endmodule

// File: rtl/vnu_pair_update.sv
module vnu_pair_update
    import vnu_pkg::*;
#(
    parameter int MAX_WT = 8,
    localparam int WT_W      = $clog2(MAX_WT + 1),
    localparam int SUM_W     = MSG_W + $clog2(MAX_WT + 1),
    localparam int MAX_PAIRS = (MAX_WT + 1) / 2,
    localparam int IDX_W     = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             node_start,
    input  logic [MSG_W-1:0] chan_llr,
    input  logic [WT_W-1:0]  col_wt,
    input  logic             msg_valid,
    input  logic [MSG_W-1:0] msg_a,
    input  logic [MSG_W-1:0] msg_b,
    output logic             ext_valid,
    output logic [MSG_W-1:0] ext_a,
    output logic [MSG_W-1:0] ext_b,
    output logic             ext_b_valid,
    output logic             hard_bit
);

    logic                    load_en;
    logic                    take;
    logic                    emit;
    logic                    b_live;
    logic [IDX_W-1:0]        pair_idx;
    edge_pair_t              in_pair;
    edge_pair_t              rd_pair;
    logic signed [SUM_W-1:0] total;
    msg_t                    lane_out [2];

    always_comb begin
        in_pair.lane_a = msg_t'(msg_a);
        in_pair.lane_b = b_live ? msg_t'(msg_b) : '0;
        in_pair.b_live = b_live;
    end

    vnu_seq #(.MAX_WT(MAX_WT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .node_start (node_start),
        .col_wt     (col_wt),
        .msg_valid  (msg_valid),
        .load_en    (load_en),
        .take       (take),
        .emit       (emit),
        .b_live     (b_live),
        .pair_idx   (pair_idx)
    );

    vnu_pair_store #(.MAX_WT(MAX_WT)) u_store (
        .clk     (clk),
        .wr_en   (take),
        .idx     (pair_idx),
        .wr_pair (in_pair),
        .rd_pair (rd_pair)
    );

    vnu_sum_acc #(.MAX_WT(MAX_WT)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .add_en  (take),
        .llr     (msg_t'(chan_llr)),
        .pair    (in_pair),
        .total   (total)
    );

    vnu_extrinsic #(.SUM_W(SUM_W)) u_ext (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .total     (total),
        .rd_pair   (rd_pair),
        .lane_o    (lane_out),
        .valid_o   (ext_valid),
        .b_valid_o (ext_b_valid),
        .hard_o    (hard_bit)
    );

    assign ext_a = lane_out[0];
    assign ext_b = lane_out[1];

endmodule

// File: rtl/vnu_pair_update_chk.sv
module vnu_pair_update_chk
    import vnu_pkg::*;
#(
    parameter int MAX_WT = 8,
    localparam int WT_W      = $clog2(MAX_WT + 1),
    localparam int MAX_PAIRS = (MAX_WT + 1) / 2
)(
    input logic             clk,
    input logic             rst,
    input logic             node_start,
    input logic [WT_W-1:0]  col_wt,
    input logic             ext_valid,
    input logic [MSG_W-1:0] ext_a,
    input logic [MSG_W-1:0] ext_b,
    input logic             ext_b_valid,
    input logic             hard_bit
);

    localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {(MSG_W - 1){1'b0}}};

    int run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 0;
        end else if (ext_valid) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R1
    quiet_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_valid |-> (ext_a == '0) && (ext_b == '0));

    // R2
    weight_range_chk: assert property (@(posedge clk) disable iff (rst)
        node_start |-> (col_wt >= 1) && (col_wt <= WT_W'(MAX_WT)));

    // R5
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> run_q < MAX_PAIRS);

    // R7
    clip_a_chk: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> ext_a != MOST_NEG);

    // R7
    clip_b_chk: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> ext_b != MOST_NEG);

    // R8
    b_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ext_b_valid |-> ext_valid);

    // R8
    masked_b_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && !ext_b_valid) |-> ext_b == '0);

    // R9
    hard_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_valid |-> $stable(hard_bit));

    // R9
    hard_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && $past(ext_valid)) |-> $stable(hard_bit));

endmodule

bind vnu_pair_update vnu_pair_update_chk #(.MAX_WT(MAX_WT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .node_start  (node_start),
    .col_wt      (col_wt),
    .ext_valid   (ext_valid),
    .ext_a       (ext_a),
    .ext_b       (ext_b),
    .ext_b_valid (ext_b_valid),
    .hard_bit    (hard_bit)
);

// File: tb/vnu_pair_update_bench.sv
`timescale 1ns/1ps
module vnu_pair_update_bench;
    import vnu_pkg::*;

    localparam int MAX_WT = 8;
    localparam int WT_W   = $clog2(MAX_WT + 1);
    localparam int LIM    = (1 << (MSG_W - 1)) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             node_start = 1'b0;
    logic [MSG_W-1:0] chan_llr = '0;
    logic [WT_W-1:0]  col_wt = '0;
    logic             msg_valid = 1'b0;
    logic [MSG_W-1:0] msg_a = '0;
    logic [MSG_W-1:0] msg_b = '0;
    logic             ext_valid;
    logic [MSG_W-1:0] ext_a;
    logic [MSG_W-1:0] ext_b;
    logic             ext_b_valid;
    logic             hard_bit;

    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    bit    monitor_on = 1'b0;
    bit    held_h = 1'b0;
    int    q_cyc[$];
    int    q_a[$];
    int    q_b[$];
    int    q_bv[$];
    int    q_h[$];
    string q_ta[$];
    string q_tb[$];

    vnu_pair_update #(.MAX_WT(MAX_WT)) u_vnu_pair_update (
        .clk         (clk),
        .rst         (rst),
        .node_start  (node_start),
        .chan_llr    (chan_llr),
        .col_wt      (col_wt),
        .msg_valid   (msg_valid),
        .msg_a       (msg_a),
        .msg_b       (msg_b),
        .ext_valid   (ext_valid),
        .ext_a       (ext_a),
        .ext_b       (ext_b),
        .ext_b_valid (ext_b_valid),
        .hard_bit    (hard_bit)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int clip(input int v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the behavioural expectation queue
    always @(negedge clk) begin
        if (monitor_on) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                chk("R5", "ext_valid", int'(ext_valid), 1);
                chk(q_ta[0], "ext_a", int'($signed(ext_a)), q_a[0]);
                chk("R8", "ext_b_valid", int'(ext_b_valid), q_bv[0]);
                chk(q_tb[0], "ext_b", int'($signed(ext_b)), q_b[0]);
                chk("R4", "hard_bit", int'(hard_bit), q_h[0]);
                held_h = q_h[0][0];
                void'(q_cyc.pop_front());
                void'(q_a.pop_front());
                void'(q_b.pop_front());
                void'(q_bv.pop_front());
                void'(q_h.pop_front());
                void'(q_ta.pop_front());
                void'(q_tb.pop_front());
            end else begin
                chk("R5", "ext_valid idle", int'(ext_valid), 0);
                chk("R1", "ext_a idle", int'($signed(ext_a)), 0);
                chk("R1", "ext_b idle", int'($signed(ext_b)), 0);
                chk("R8", "ext_b_valid idle", int'(ext_b_valid), 0);
                chk("R9", "hard_bit hold", int'(hard_bit), int'(held_h));
            end
        end
    end

    // Drive one node; gaps inserts idle cycles (R10), poke issues a stray start (R2)
    task automatic run_node(input int llr, input int wt, input int m[$],
                            input bit gaps, input bit poke);
        int np;
        int total;
        int c;
        np = (wt + 1) / 2;
        total = llr;
        for (int k = 0; k < wt; k++) total += m[k];
        @(negedge clk);
        node_start = 1'b1;
        chan_llr   = MSG_W'(llr);
        col_wt     = WT_W'(wt);
        @(negedge clk);
        node_start = 1'b0;
        for (int p = 0; p < np; p++) begin
            if (gaps && (p % 2 == 0)) begin
                msg_valid = 1'b0;
                msg_a = MSG_W'(13);
                @(negedge clk);
            end
            if (poke && p == 0) begin
                node_start = 1'b1;
                chan_llr   = MSG_W'(-llr - 1);
                col_wt     = WT_W'(1);
            end
            msg_valid = 1'b1;
            msg_a = MSG_W'(m[2*p]);
            msg_b = (2*p + 1 < wt) ? MSG_W'(m[2*p+1]) : MSG_W'(-23);
            if (p == np - 1) begin
                c = cyc;
                for (int j = 0; j < np; j++) begin
                    int ra;
                    int rb;
                    bit bl;
                    bl = (2*j + 1 < wt);
                    ra = total - m[2*j];
                    rb = bl ? total - m[2*j+1] : 0;
                    q_cyc.push_back(c + 2 + j);
                    q_a.push_back(clip(ra));
                    q_ta.push_back((clip(ra) != ra) ? "R7" : "R6");
                    q_b.push_back(clip(rb));
                    q_tb.push_back(!bl ? "R8" : ((clip(rb) != rb) ? "R7" : "R6"));
                    q_bv.push_back(bl ? 1 : 0);
                    q_h.push_back(total < 0 ? 1 : 0);
                end
            end
            @(negedge clk);
            node_start = 1'b0;
        end
        msg_valid = 1'b0;
        msg_a = '0;
        msg_b = '0;
        while (q_cyc.size() > 0) @(negedge clk);
    endtask

    task automatic rand_node(input int wt, input bit gaps, input bit poke);
        int m[$];
        int llr;
        llr = int'($urandom_range(0, 63)) - 32;
        for (int k = 0; k < wt; k++) m.push_back(int'($urandom_range(0, 63)) - 32);
        run_node(llr, wt, m, gaps, poke);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL R5 watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int m[$];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ext_valid reset", int'(ext_valid), 0);
        chk("R1", "ext_b_valid reset", int'(ext_b_valid), 0);
        chk("R1", "hard_bit reset", int'(hard_bit), 0);
        chk("R1", "ext_a reset", int'($signed(ext_a)), 0);
        chk("R1", "ext_b reset", int'($signed(ext_b)), 0);
        rst = 1'b0;
        monitor_on = 1'b1;
        @(negedge clk);

        // R8: weight 1, lane b masked; R4 total -4 gives hard 1
        m = {-9};
        run_node(5, 1, m, 1'b0, 1'b0);
        // R9: zero total gives hard 0
        m = {-3, 0};
        run_node(3, 2, m, 1'b0, 1'b0);
        // R7: positive saturation
        m = {31, 31, 31, 31, 31, 31, 31, 31};
        run_node(31, 8, m, 1'b0, 1'b0);
        // R7: negative saturation and most negative inputs
        m = {-32, -32, -32, -32, -32, -32, -32};
        run_node(-32, 7, m, 1'b0, 1'b0);
        // R6: ordering with distinct values
        m = {1, 2, 3, 4, 5};
        run_node(0, 5, m, 1'b0, 1'b0);

        // R3: msg_valid while idle must not reach the next node
        @(negedge clk);
        msg_valid = 1'b1;
        msg_a = MSG_W'(30);
        msg_b = MSG_W'(30);
        repeat (3) @(negedge clk);
        msg_valid = 1'b0;
        m = {-4, 6, -8};
        run_node(2, 3, m, 1'b0, 1'b0);

        // R10: gaps during gathering
        m = {10, -20, 7, 3, -1, 2};
        run_node(-6, 6, m, 1'b1, 1'b0);
        // R2: start while busy ignored
        m = {8, -2, 5, 9};
        run_node(-11, 4, m, 1'b0, 1'b1);

        // Every weight, every mode, random data (R4, R6, R8)
        for (int w = 1; w <= MAX_WT; w++) begin
            rand_node(w, 1'b0, 1'b0);
            rand_node(w, 1'b1, 1'b0);
            rand_node(w, 1'b0, 1'b1);
        end
        for (int n = 0; n < 40; n++) begin
            rand_node(int'($urandom_range(1, MAX_WT)), n[0], n[1] & n[2]);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule